// File: doc/BRIEF.md
# DDR3 Burst and Latency Timing Generator

This block sits on the controller side of a DDR3 memory interface. It takes one read or write command at a time and drives the command/address fields: type, a 3-bit bank that selects one of 8 logical banks, and the burst-chop level placed on address bit A12. It then opens the data window for that command after the configured delay, with per-cycle read-capture and write-drive enables and a beat index.

The data path is modelled at half rate. Two beats move on each controller clock, so a full 8-beat burst takes 4 cycles. A chopped burst moves 4 beats in the first 2 cycles, but it still holds the whole 4-cycle slot. All latencies are counted in controller clock cycles.

The read delay is additive latency plus CAS latency. The write delay is additive latency plus write latency. Additive latency is not a free value: it comes from one of three modes derived from the CAS latency. A burst that has been issued cannot be cut short. The requester sees the ready signal low and must hold its command until the whole slot is over. Configuration is written through a simple strobe. It is taken only while nothing is in flight, and values outside the legal ranges are refused and flagged.

Top module: `burst_lat_sched`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. In the next cycle only, `issue_valid` is high and `issue_write`, `issue_bank` (3 bits, banks 0 to 7) and `issue_a12` (equal to `cmd_chop`) show the captured command.
- R2: For a read, `rd_en` is first high exactly AL+CL cycles after the cycle in which `issue_valid` is high. Before that, both enables stay low.
- R3: For a write, `wr_en` is first high exactly AL+CWL cycles after the `issue_valid` cycle. The write latency is independent of CL.
- R4: `cfg_al_mode` encoding: 0 gives AL=0, 1 gives AL=CL-1, 2 gives AL=CL-2, and 3 is illegal.
- R5: A full burst (`cmd_chop`=0) keeps its enable high for 4 consecutive cycles with `beat_idx` equal to 0, 2, 4, 6. The index names the first of the two beats moved in that cycle. `rd_en` and `wr_en` are never high together.
- R6: A chopped burst (`cmd_chop`=1) keeps its enable high for the first 2 cycles of the slot only, with `beat_idx` 0 and 2. The enable and `beat_idx` are low/0 in the last 2 slot cycles.
- R7: `cmd_ready` is low from the acceptance edge until the end of the 4-cycle data slot, and is high again in the cycle after the last slot cycle. A command held during this time is accepted only then.
- R8: Legal CL is 5 to 11 and legal CWL is 5 to 10. A configuration write with an illegal CL, CWL or AL mode leaves the stored setting unchanged and raises `cfg_err` for exactly the next cycle.
- R9: A configuration write while a command is in flight, or in the same cycle as an acceptance, is ignored: the stored setting is unchanged and `cfg_err` stays low.
- R10: While reset is asserted, and until the synchronised release, `cmd_ready`, `issue_valid`, `rd_en` and `wr_en` are low. After reset the setting is CL=5, AL mode 0, CWL=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 3 | Target logical bank |
| cmd_chop | input | 1 | 1 = chopped 4-beat burst |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cl | input | 4 | CAS latency in cycles |
| cfg_al_mode | input | 2 | Additive latency mode |
| cfg_cwl | input | 4 | Write latency in cycles |
| cfg_err | output | 1 | Previous configuration write refused |
| issue_valid | output | 1 | Command/address drive valid |
| issue_write | output | 1 | Issued command type |
| issue_bank | output | 3 | Issued bank |
| issue_a12 | output | 1 | Burst-chop level on A12 |
| rd_en | output | 1 | Read capture enable |
| wr_en | output | 1 | Write drive enable |
| beat_idx | output | 3 | First beat index of this cycle's pair |

## Verification
Each command produces a fixed timetable. The issue fields appear one cycle after the acceptance edge. The first enabled data cycle falls exactly AL+CL (read) or AL+CWL (write) cycles after the issue cycle. The slot lasts four cycles, and ready returns in the fifth. The directed tasks drive inputs on the falling edge and then step one falling edge at a time from the issue cycle. At each step they compare the enables, the beat index and the ready level with this timetable. A refused configuration write must show `cfg_err` exactly one cycle after its strobe. An ignored configuration write is confirmed by timing the next command against the old latency.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int BURST_BEATS   = 8;
  localparam int BEATS_PER_CLK = 2;
  localparam int BANK_W        = 3;
  localparam int LAT_CFG_W     = 4;
  localparam int CL_MIN        = 5;
  localparam int CL_MAX        = 11;
  localparam int CWL_MIN       = 5;
  localparam int CWL_MAX       = 10;
  localparam int SYNC_STAGES   = 2;

  typedef enum logic [1:0] {
    AL_NONE  = 2'd0,
    AL_CL_M1 = 2'd1,
    AL_CL_M2 = 2'd2
  } al_mode_e;

  typedef enum logic [1:0] {
    WIN_IDLE,
    WIN_WAIT,
    WIN_DATA
  } win_state_e;
endpackage

// File: rtl/blt_rst_sync.sv
module blt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/blt_cfg.sv
module blt_cfg
  import blt_pkg::*;
#(
  parameter int CFG_W   = LAT_CFG_W,
  parameter int CLMIN   = CL_MIN,
  parameter int CLMAX   = CL_MAX,
  parameter int CWLMIN  = CWL_MIN,
  parameter int CWLMAX  = CWL_MAX,
  localparam int LAT_W  = CFG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             allow,
  input  logic [CFG_W-1:0] cl_in,
  input  logic [1:0]       al_in,
  input  logic [CFG_W-1:0] cwl_in,
  output logic [LAT_W-1:0] rd_lat,
  output logic [LAT_W-1:0] wr_lat,
  output logic             err
);
  logic [CFG_W-1:0] cl_q, cl_d, cwl_q, cwl_d;
  al_mode_e         al_q, al_d;
  logic             err_q, err_d;
  logic             legal;
  logic [LAT_W-1:0] al_val;

  always_comb begin
    legal = (cl_in  >= CFG_W'(CLMIN))  && (cl_in  <= CFG_W'(CLMAX)) &&
            (cwl_in >= CFG_W'(CWLMIN)) && (cwl_in <= CFG_W'(CWLMAX)) &&
            (al_in != 2'd3);
    cl_d  = cl_q;
    cwl_d = cwl_q;
    al_d  = al_q;
    err_d = 1'b0;
    if (wr_req && allow) begin
      if (legal) begin
        cl_d  = cl_in;
        cwl_d = cwl_in;
        al_d  = al_mode_e'(al_in);
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q  <= CFG_W'(CLMIN);
      cwl_q <= CFG_W'(CWLMIN);
      al_q  <= AL_NONE;
      err_q <= 1'b0;
    end else begin
      cl_q  <= cl_d;
      cwl_q <= cwl_d;
      al_q  <= al_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    case (al_q)
      AL_CL_M1: al_val = LAT_W'(cl_q) - LAT_W'(1);
      AL_CL_M2: al_val = LAT_W'(cl_q) - LAT_W'(2);
      default:  al_val = '0;
    endcase
    rd_lat = al_val + LAT_W'(cl_q);
    wr_lat = al_val + LAT_W'(cwl_q);
  end

  assign err = err_q;
endmodule

// File: rtl/blt_window.sv
module blt_window
  import blt_pkg::*;
#(
  parameter int BEATS   = BURST_BEATS,
  parameter int PER_CLK = BEATS_PER_CLK,
  parameter int LAT_W   = LAT_CFG_W + 1,
  localparam int SLOT   = BEATS / PER_CLK,
  localparam int CHOP   = SLOT / 2,
  localparam int SLOT_W = $clog2(SLOT),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_chop,
  input  logic [LAT_W-1:0]  lat,
  output logic              busy,
  output logic              rd_en,
  output logic              wr_en,
  output logic [BEAT_W-1:0] beat_idx
);
  win_state_e        state_q, state_d;
  logic [LAT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              wr_q, wr_d, chop_q, chop_d;
  logic              en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    slot_d  = slot_q;
    wr_d    = wr_q;
    chop_d  = chop_q;
    case (state_q)
      WIN_IDLE: begin
        if (start) begin
          state_d = WIN_WAIT;
          cnt_d   = lat;
          wr_d    = start_wr;
          chop_d  = start_chop;
        end
      end
      WIN_WAIT: begin
        cnt_d = cnt_q - LAT_W'(1);
        if (cnt_q == LAT_W'(1)) begin
          state_d = WIN_DATA;
          slot_d  = '0;
        end
      end
      WIN_DATA: begin
        slot_d = slot_q + SLOT_W'(1);
        if (slot_q == SLOT_W'(SLOT - 1)) state_d = WIN_IDLE;
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      wr_q    <= 1'b0;
      chop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      wr_q    <= wr_d;
      chop_q  <= chop_d;
    end
  end

  always_comb begin
    busy     = (state_q != WIN_IDLE);
    en       = (state_q == WIN_DATA) && (!chop_q || (slot_q < SLOT_W'(CHOP)));
    rd_en    = en && !wr_q;
    wr_en    = en && wr_q;
    beat_idx = en ? BEAT_W'(BEAT_W'(slot_q) * BEAT_W'(PER_CLK)) : '0;
  end
endmodule

// File: rtl/burst_lat_sched.sv
module burst_lat_sched
  import blt_pkg::*;
#(
  parameter int BANKW   = BANK_W,
  parameter int CFG_W   = LAT_CFG_W,
  parameter int BEATS   = BURST_BEATS,
  parameter int PER_CLK = BEATS_PER_CLK,
  localparam int LAT_W  = CFG_W + 1,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANKW-1:0]  cmd_bank,
  input  logic              cmd_chop,
  output logic              cmd_ready,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_cl,
  input  logic [1:0]        cfg_al_mode,
  input  logic [CFG_W-1:0]  cfg_cwl,
  output logic              cfg_err,
  output logic              issue_valid,
  output logic              issue_write,
  output logic [BANKW-1:0]  issue_bank,
  output logic              issue_a12,
  output logic              rd_en,
  output logic              wr_en,
  output logic [BEAT_W-1:0] beat_idx
);
  logic             rst_ok_n;
  logic             busy, accept;
  logic [LAT_W-1:0] rd_lat, wr_lat, sel_lat;
  logic             iv_q, iv_d, iw_q, iw_d, ia_q, ia_d;
  logic [BANKW-1:0] ib_q, ib_d;

  blt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n)
  );

  assign cmd_ready = rst_ok_n && !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign sel_lat   = cmd_write ? wr_lat : rd_lat;

  blt_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_ok_n), .wr_req(cfg_wr),
    .allow(cmd_ready && !accept),
    .cl_in(cfg_cl), .al_in(cfg_al_mode), .cwl_in(cfg_cwl),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .err(cfg_err)
  );

  blt_window #(.BEATS(BEATS), .PER_CLK(PER_CLK), .LAT_W(LAT_W)) u_win (
    .clk(clk), .rst_n(rst_ok_n), .start(accept),
    .start_wr(cmd_write), .start_chop(cmd_chop), .lat(sel_lat),
    .busy(busy), .rd_en(rd_en), .wr_en(wr_en), .beat_idx(beat_idx)
  );

  always_comb begin
    iv_d = accept;
    iw_d = iw_q;
    ia_d = ia_q;
    ib_d = ib_q;
    if (accept) begin
      iw_d = cmd_write;
      ia_d = cmd_chop;
      ib_d = cmd_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      iv_q <= 1'b0;
      iw_q <= 1'b0;
      ia_q <= 1'b0;
      ib_q <= '0;
    end else begin
      iv_q <= iv_d;
      iw_q <= iw_d;
      ia_q <= ia_d;
      ib_q <= ib_d;
    end
  end

  assign issue_valid = iv_q;
  assign issue_write = iw_q;
  assign issue_a12   = ia_q;
  assign issue_bank  = ib_q;
endmodule

// File: rtl/blt_checker.sv
module blt_checker #(
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cfg_wr,
  input logic              cfg_err,
  input logic              issue_valid,
  input logic              rd_en,
  input logic              wr_en,
  input logic [BEAT_W-1:0] beat_idx
);
  p_issue_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> issue_valid);

  p_issue_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !cmd_ready);

  p_no_interrupt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> !cmd_ready);

  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_even_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> (beat_idx[0] == 1'b0));

  p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (beat_idx == $past(beat_idx) + BEAT_W'(2)));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_wr));
endmodule

bind burst_lat_sched blt_checker #(.BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cfg_wr(cfg_wr), .cfg_err(cfg_err), .issue_valid(issue_valid),
  .rd_en(rd_en), .wr_en(wr_en), .beat_idx(beat_idx)
);

// File: tb/burst_lat_sched_test.sv
`timescale 1ns/1ps
module burst_lat_sched_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_write, cmd_chop, cmd_ready;
  logic [2:0] cmd_bank;
  logic       cfg_wr, cfg_err;
  logic [3:0] cfg_cl, cfg_cwl;
  logic [1:0] cfg_al_mode;
  logic       issue_valid, issue_write, issue_a12;
  logic [2:0] issue_bank;
  logic       rd_en, wr_en;
  logic [2:0] beat_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  burst_lat_sched uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_chop(cmd_chop), .cmd_ready(cmd_ready),
    .cfg_wr(cfg_wr), .cfg_cl(cfg_cl), .cfg_al_mode(cfg_al_mode),
    .cfg_cwl(cfg_cwl), .cfg_err(cfg_err), .issue_valid(issue_valid),
    .issue_write(issue_write), .issue_bank(issue_bank), .issue_a12(issue_a12),
    .rd_en(rd_en), .wr_en(wr_en), .beat_idx(beat_idx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input bit wr, input int bank, input bit chop,
                         input int lat, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_bank = 3'(bank); cmd_chop = chop;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(issue_valid == 1'b1, "R1", "issue_valid", int'(issue_valid), 1);
    check(issue_write == wr, "R1", "issue_write", int'(issue_write), int'(wr));
    check(int'(issue_bank) == bank, "R1", "issue_bank", int'(issue_bank), bank);
    check(issue_a12 == chop, "R6", "issue_a12", int'(issue_a12), int'(chop));
    for (int m = 1; m < lat; m++) begin
      @(negedge clk);
      check(!rd_en && !wr_en, req, "enable before latency", int'(rd_en | wr_en), 0);
      check(!cmd_ready, "R7", "ready while waiting", int'(cmd_ready), 0);
    end
    for (int p = 0; p < 4; p++) begin
      bit en;
      @(negedge clk);
      en = !chop || (p < 2);
      check(rd_en == (en && !wr), chop ? "R6" : "R5", "rd_en in slot", int'(rd_en), int'(en && !wr));
      check(wr_en == (en && wr), chop ? "R6" : "R5", "wr_en in slot", int'(wr_en), int'(en && wr));
      check(int'(beat_idx) == (en ? 2 * p : 0), "R5", "beat_idx", int'(beat_idx), en ? 2 * p : 0);
      check(!cmd_ready, "R7", "ready during slot", int'(cmd_ready), 0);
    end
    @(negedge clk);
    check(cmd_ready, "R7", "ready after slot", int'(cmd_ready), 1);
  endtask

  task automatic cfg_write(input int cl, input int al, input int cwl,
                           input bit exp_err, input string req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_cl = 4'(cl); cfg_al_mode = 2'(al); cfg_cwl = 4'(cwl);
    @(negedge clk);
    cfg_wr = 1'b0;
    check(cfg_err == exp_err, req, "cfg_err", int'(cfg_err), int'(exp_err));
    @(negedge clk);
    check(cfg_err == 1'b0, req, "cfg_err one cycle", int'(cfg_err), 0);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_write = 0; cmd_bank = 0; cmd_chop = 0;
    cfg_wr = 0; cfg_cl = 0; cfg_al_mode = 0; cfg_cwl = 0;
    repeat (3) @(negedge clk);
    check(!cmd_ready, "R10", "ready in reset", int'(cmd_ready), 0);
    check(!issue_valid && !rd_en && !wr_en, "R10", "outputs in reset",
          int'(issue_valid | rd_en | wr_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready, "R10", "ready after reset", int'(cmd_ready), 1);
  endtask

  task automatic test_defaults;
    run_cmd(1'b0, 3, 1'b0, 5, "R10");
    run_cmd(1'b1, 0, 1'b0, 5, "R10");
  endtask

  task automatic test_write_lat;
    cfg_write(5, 0, 7, 1'b0, "R3");
    run_cmd(1'b1, 6, 1'b0, 7, "R3");
    run_cmd(1'b0, 2, 1'b0, 5, "R2");
  endtask

  task automatic test_chop;
    run_cmd(1'b0, 1, 1'b1, 5, "R6");
    run_cmd(1'b1, 7, 1'b1, 7, "R6");
  endtask

  task automatic test_al_modes;
    cfg_write(6, 1, 7, 1'b0, "R4");
    run_cmd(1'b0, 4, 1'b0, 11, "R4");
    run_cmd(1'b1, 4, 1'b0, 12, "R4");
    cfg_write(7, 2, 6, 1'b0, "R4");
    run_cmd(1'b0, 5, 1'b0, 12, "R4");
    run_cmd(1'b1, 2, 1'b1, 11, "R4");
  endtask

  task automatic test_illegal_cfg;
    cfg_write(12, 0, 5, 1'b1, "R8");
    cfg_write(4, 0, 5, 1'b1, "R8");
    cfg_write(6, 3, 5, 1'b1, "R8");
    cfg_write(6, 0, 11, 1'b1, "R8");
    run_cmd(1'b0, 0, 1'b0, 12, "R8");
    run_cmd(1'b1, 0, 1'b0, 11, "R8");
  endtask

  task automatic test_cfg_in_flight;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 3'd6; cmd_chop = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_cl = 4'd5; cfg_al_mode = 2'd0; cfg_cwl = 4'd5;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(!cfg_err, "R9", "no flag mid-burst", int'(cfg_err), 0);
    for (int g = 0; g < 40 && !cmd_ready; g++) @(negedge clk);
    // same-cycle write and acceptance: write ignored
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 3'd1; cmd_chop = 1'b0;
    cfg_wr = 1'b1; cfg_cl = 4'd9; cfg_al_mode = 2'd0; cfg_cwl = 4'd9;
    @(negedge clk);
    cmd_valid = 1'b0; cfg_wr = 1'b0;
    check(!cfg_err, "R9", "no flag on accept cycle", int'(cfg_err), 0);
    for (int g = 0; g < 40 && !cmd_ready; g++) @(negedge clk);
    run_cmd(1'b0, 3, 1'b0, 12, "R9");
  endtask

  task automatic test_hold;
    int m;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 3'd2; cmd_chop = 1'b0;
    @(negedge clk);
    cmd_write = 1'b1; cmd_bank = 3'd5; cmd_chop = 1'b1;
    m = 0;
    do begin
      @(negedge clk);
      m++;
    end while (!issue_valid && m < 40);
    cmd_valid = 1'b0;
    check(m == 17, "R7", "held command issue delay", m, 17);
    check(issue_write && issue_bank == 3'd5 && issue_a12, "R7", "held command fields",
          int'({issue_write, issue_bank, issue_a12}), 5'b11011);
    for (int g = 0; g < 40 && !cmd_ready; g++) @(negedge clk);
  endtask

  initial begin
    test_reset();
    test_defaults();
    test_write_lat();
    test_chop();
    test_al_modes();
    test_illegal_cfg();
    test_cfg_in_flight();
    test_hold();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule